// File: doc/BRIEF.md
# Multichannel PWM Generator Bank

This block holds twelve independent pulse-width channels that share one system clock, nominally 25 MHz. Each channel has a 16-bit period and a 16-bit duty value, both counted in clock cycles. A host loads them one byte at a time over a simple byte-wide write port. A combinational read port returns any register byte. For a wanted output frequency the host writes the period as the clock frequency divided by that frequency. It writes the duty as the number of cycles the output should stay high. For example, 500 Hz at half duty takes a period of 50000 (0xC350) and a duty of 25000.

Two control bytes hold one enable bit per channel and a global enable. A channel runs only while its own bit and the global bit are both set. While it is stopped, its output is low and its counter sits at zero. A running channel keeps the period and duty it is using in a shadow copy. That copy is refreshed only when the counter wraps. The host can therefore rewrite both bytes of a value within a period, and the output never runs a period built from half of an old value and half of a new one.

Top module: `pwm_bank`

## Requirements
- R1: An enabled channel with period P (P >= 2) and 0 < duty D < P produces rising edges exactly P cycles apart.
- R2: In each period the output is high for the first D cycles and low for the remaining P - D cycles.
- R3: Period 50000 and duty 25000 give 25000 high cycles followed by 25000 low cycles, then a new rising edge.
- R4: Channel c has its period low byte at address 0x10 + 2c and high byte at 0x11 + 2c, and its duty low byte at 0x40 + 2c and high byte at 0x41 + 2c. All of these read back as written.
- R5: Address 0x00 bit c enables channel c for c = 0..7. At address 0x01, bits 3:0 enable channels 8..11 and bit 7 is the global enable. Bits 6:4 of address 0x01 read as zero whatever was written.
- R6: While the global enable is clear, every output is low, from the second clock edge after the write that clears it.
- R7: A disabled channel's output is low. Enabling it restarts its count from zero, and its output is high in the first cycle after the enabling write when D > 0.
- R8: Period and duty writes to a running channel take effect only at the next counter wrap. The period in progress completes with the old values.
- R9: A duty greater than or equal to the period gives a constantly high output. A duty of zero gives a constantly low output.
- R10: After reset every output is low and every register reads zero.
- R11: Channels run concurrently with independent periods and duties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe, one write per cycle |
| wr_addr | input | 8 | Write register address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read register address |
| rd_data | output | 8 | Read data byte (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with its default of twelve channels and 16-bit counters. It can therefore reach the split enable byte for channels 8 to 11, the top duty address, and the full 50000-cycle period. Most scenarios use short periods of five to twenty cycles, so several wraps, restarts and mid-period rewrites fit in a short run. One scenario runs a full 16-bit period, which checks that the carry between the byte halves of the counter and the registers is handled correctly.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned CNT_W   = 2 * BYTE_W;
    localparam int unsigned MAX_CH  = 12;

    localparam logic [BYTE_W-1:0] ADDR_EN_LO     = 8'h00;
    localparam logic [BYTE_W-1:0] ADDR_EN_HI     = 8'h01;
    localparam logic [BYTE_W-1:0] ADDR_PER_BASE  = 8'h10;
    localparam logic [BYTE_W-1:0] ADDR_DUTY_BASE = 8'h40;

    localparam int unsigned GLOBAL_BIT = 7;
    localparam int unsigned HI_EN_BITS = 4;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_mode_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [BYTE_W-1:0]              wr_addr,
    input  logic [BYTE_W-1:0]              wr_data,
    input  logic [BYTE_W-1:0]              rd_addr,
    output logic [BYTE_W-1:0]              rd_data,
    output logic [NUM_CH-1:0]              ch_en_o,
    output logic                           glob_en_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   per_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   duty_o
);

    localparam int unsigned EN_W = 2 * BYTE_W;

    typedef struct packed {
        logic [NUM_CH-1:0]            en;
        logic                         glob;
        logic [NUM_CH-1:0][CNT_W-1:0] per;
        logic [NUM_CH-1:0][CNT_W-1:0] duty;
    } regs_t;

    regs_t r_d, r_q;
    logic [EN_W-1:0] en_wide_w;
    logic [EN_W-1:0] en_wide_r;

    always_comb begin
        r_d       = r_q;
        en_wide_w = '0;
        en_wide_w[NUM_CH-1:0] = r_q.en;
        if (wr_en) begin
            if (wr_addr == ADDR_EN_LO) begin
                en_wide_w[BYTE_W-1:0] = wr_data;
            end
            if (wr_addr == ADDR_EN_HI) begin
                en_wide_w[BYTE_W +: HI_EN_BITS] = wr_data[HI_EN_BITS-1:0];
                r_d.glob = wr_data[GLOBAL_BIT];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_addr == ADDR_PER_BASE + BYTE_W'(2 * c))
                    r_d.per[c][BYTE_W-1:0] = wr_data;
                if (wr_addr == ADDR_PER_BASE + BYTE_W'(2 * c + 1))
                    r_d.per[c][CNT_W-1:BYTE_W] = wr_data;
                if (wr_addr == ADDR_DUTY_BASE + BYTE_W'(2 * c))
                    r_d.duty[c][BYTE_W-1:0] = wr_data;
                if (wr_addr == ADDR_DUTY_BASE + BYTE_W'(2 * c + 1))
                    r_d.duty[c][CNT_W-1:BYTE_W] = wr_data;
            end
        end
        r_d.en = en_wide_w[NUM_CH-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data   = '0;
        en_wide_r = '0;
        en_wide_r[NUM_CH-1:0] = r_q.en;
        if (rd_addr == ADDR_EN_LO) begin
            rd_data = en_wide_r[BYTE_W-1:0];
        end
        if (rd_addr == ADDR_EN_HI) begin
            rd_data[HI_EN_BITS-1:0] = en_wide_r[BYTE_W +: HI_EN_BITS];
            rd_data[GLOBAL_BIT]     = r_q.glob;
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_PER_BASE + BYTE_W'(2 * c))
                rd_data = r_q.per[c][BYTE_W-1:0];
            if (rd_addr == ADDR_PER_BASE + BYTE_W'(2 * c + 1))
                rd_data = r_q.per[c][CNT_W-1:BYTE_W];
            if (rd_addr == ADDR_DUTY_BASE + BYTE_W'(2 * c))
                rd_data = r_q.duty[c][BYTE_W-1:0];
            if (rd_addr == ADDR_DUTY_BASE + BYTE_W'(2 * c + 1))
                rd_data = r_q.duty[c][CNT_W-1:BYTE_W];
        end
    end

    assign ch_en_o   = r_q.en;
    assign glob_en_o = r_q.glob;
    assign per_o     = r_q.per;
    assign duty_o    = r_q.duty;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
#(
    parameter int unsigned CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [CW-1:0] per_i,
    input  logic [CW-1:0] duty_i,
    output logic          pwm_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] per_act_o,
    output logic [CW-1:0] duty_act_o
);

    typedef struct packed {
        ch_mode_e      mode;
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
        logic [CW-1:0] duty;
        logic          out;
    } chan_t;

    chan_t s_d, s_q;
    logic [CW:0] cnt_inc;
    logic        at_wrap;

    always_comb begin
        s_d     = s_q;
        cnt_inc = {1'b0, s_q.cnt} + {{CW{1'b0}}, 1'b1};
        at_wrap = cnt_inc >= {1'b0, s_q.per};
        if (!run_i) begin
            s_d.mode = CH_IDLE;
            s_d.cnt  = '0;
            s_d.per  = per_i;
            s_d.duty = duty_i;
        end else if (s_q.mode == CH_IDLE || at_wrap) begin
            s_d.mode = CH_RUN;
            s_d.cnt  = '0;
            s_d.per  = per_i;
            s_d.duty = duty_i;
        end else begin
            s_d.cnt  = cnt_inc[CW-1:0];
        end
        s_d.out = (s_d.mode == CH_RUN) && (s_d.cnt < s_d.duty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o      = s_q.out;
    assign cnt_o      = s_q.cnt;
    assign per_act_o  = s_q.per;
    assign duty_act_o = s_q.duty;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = MAX_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0]            ch_en;
    logic                         glob_en;
    logic [NUM_CH-1:0][CNT_W-1:0] per_reg;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_reg;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_now;
    logic [NUM_CH-1:0][CNT_W-1:0] per_act;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_act;

    pwm_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ch_en_o   (ch_en),
        .glob_en_o (glob_en),
        .per_o     (per_reg),
        .duty_o    (duty_reg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_channel #(.CW(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_i      (ch_en[c] & glob_en),
            .per_i      (per_reg[c]),
            .duty_i     (duty_reg[c]),
            .pwm_o      (pwm_out[c]),
            .cnt_o      (cnt_now[c]),
            .per_act_o  (per_act[c]),
            .duty_act_o (duty_act[c])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH = MAX_CH
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [7:0]                   wr_addr,
    input logic [7:0]                   wr_data,
    input logic [7:0]                   rd_addr,
    input logic [7:0]                   rd_data,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_now,
    input logic [NUM_CH-1:0][CNT_W-1:0] per_act,
    input logic [NUM_CH-1:0][CNT_W-1:0] duty_act
);

    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_EN_HI) |-> (rd_data[6:4] == 3'b000));

    p_global_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_EN_HI && !wr_data[GLOBAL_BIT]) |=> ##1 (pwm_out == '0));

    p_disable_ch0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_EN_LO && !wr_data[0]) |=> ##1 !pwm_out[0]);

    p_reset_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pwm_out == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_now[c] == '0) || (cnt_now[c] < per_act[c]));

        p_shadow_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(per_act[c]) || !$stable(duty_act[c])) |-> (cnt_now[c] == '0));

        p_zero_duty_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
            pwm_out[c] |-> (duty_act[c] != '0));
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out),
    .cnt_now  (cnt_now),
    .per_act  (per_act),
    .duty_act (duty_act)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

    localparam int CLK_PERIOD = 40;
    localparam int NCH        = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [7:0]     wr_addr = '0;
    logic [7:0]     wr_data = '0;
    logic [7:0]     rd_addr = '0;
    logic [7:0]     rd_data;
    logic [NCH-1:0] pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_bank #(.NUM_CH(NCH)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        rd_addr = a;
        #1;
        chk(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic set_chan(input int c, input int per, input int duty);
        reg_wr(8'h10 + 8'(2 * c), 8'(per));
        reg_wr(8'h11 + 8'(2 * c), 8'(per >> 8));
        reg_wr(8'h40 + 8'(2 * c), 8'(duty));
        reg_wr(8'h41 + 8'(2 * c), 8'(duty >> 8));
    endtask

    task automatic count_hi(input int c, input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            hits += int'(pwm_out[c]);
            @(negedge clk);
        end
    endtask

    task automatic rise_gap(input int c, output int gap);
        bit prev;
        int guard;
        prev = pwm_out[c];
        guard = 0;
        @(negedge clk);
        while (!(pwm_out[c] && !prev) && guard < 1000) begin
            prev = pwm_out[c]; @(negedge clk); guard++;
        end
        gap = 0;
        prev = pwm_out[c];
        @(negedge clk); gap++;
        while (!(pwm_out[c] && !prev) && gap < 1000) begin
            prev = pwm_out[c]; @(negedge clk); gap++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(pwm_out == '0, "R10 outputs low", pwm_out, 0);
        rd_chk(8'h00, 8'h00, "R10 enable low byte");
        rd_chk(8'h01, 8'h00, "R10 enable high byte");
        rd_chk(8'h16, 8'h00, "R10 period ch3");
    endtask

    task automatic t_regs;
        set_chan(5, 16'h1234, 16'hABCD);
        rd_chk(8'h1A, 8'h34, "R4 period low ch5");
        rd_chk(8'h1B, 8'h12, "R4 period high ch5");
        rd_chk(8'h4A, 8'hCD, "R4 duty low ch5");
        rd_chk(8'h4B, 8'hAB, "R4 duty high ch5");
        set_chan(11, 16'h00FE, 16'h7701);
        rd_chk(8'h57, 8'h77, "R4 duty high ch11");
        rd_chk(8'h26, 8'hFE, "R4 period low ch11");
        reg_wr(8'h01, 8'hFF);
        rd_chk(8'h01, 8'h8F, "R5 reserved bits read zero");
        reg_wr(8'h01, 8'h00);
        reg_wr(8'h00, 8'hA5);
        rd_chk(8'h00, 8'hA5, "R5 low enable byte");
        reg_wr(8'h00, 8'h00);
        set_chan(5, 0, 0);
        set_chan(11, 0, 0);
    endtask

    task automatic t_basic;
        int hits, gap;
        set_chan(0, 10, 3);
        reg_wr(8'h01, 8'h80);
        reg_wr(8'h00, 8'h01);
        @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R7 starts high after enable", pwm_out[0], 1);
        count_hi(0, 30, hits);
        chk(hits == 9, "R2 high cycles over three periods", hits, 9);
        rise_gap(0, gap);
        chk(gap == 10, "R1 rising edge spacing", gap, 10);
    endtask

    task automatic t_multi;
        int h0, h1, h11;
        set_chan(1, 7, 2);
        set_chan(11, 5, 4);
        reg_wr(8'h00, 8'h02);
        reg_wr(8'h01, 8'h88);
        repeat (3) @(negedge clk);
        count_hi(1, 35, h1);
        chk(h1 == 10, "R11 ch1 high count", h1, 10);
        count_hi(11, 35, h11);
        chk(h11 == 28, "R11 ch11 high count", h11, 28);
        count_hi(0, 20, h0);
        chk(h0 == 0, "R7 disabled ch0 stays low", h0, 0);
    endtask

    task automatic t_global;
        int hits;
        reg_wr(8'h01, 8'h08);
        @(negedge clk);
        hits = 0;
        for (int i = 0; i < 20; i++) begin
            hits += $countones(pwm_out);
            @(negedge clk);
        end
        chk(hits == 0, "R6 global clear silences all", hits, 0);
        reg_wr(8'h01, 8'h88);
        @(negedge clk);
        chk(pwm_out[11] == 1'b1, "R7 ch11 restarts from zero", pwm_out[11], 1);
    endtask

    task automatic t_extremes;
        int h2, h3, h4;
        set_chan(2, 6, 6);
        set_chan(3, 6, 9);
        set_chan(4, 6, 0);
        reg_wr(8'h00, 8'h1C);
        repeat (2) @(negedge clk);
        count_hi(2, 24, h2);
        chk(h2 == 24, "R9 duty equal to period", h2, 24);
        count_hi(3, 24, h3);
        chk(h3 == 24, "R9 duty above period", h3, 24);
        count_hi(4, 24, h4);
        chk(h4 == 0, "R9 zero duty", h4, 0);
    endtask

    task automatic t_wrap;
        bit smp [0:39];
        int h_old, h_new;
        reg_wr(8'h00, 8'h00);
        set_chan(0, 20, 5);
        reg_wr(8'h00, 8'h01);
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            smp[i] = pwm_out[0];
            case (i)
                1: begin wr_en = 1'b1; wr_addr = 8'h10; wr_data = 8'h0C; end
                2: begin wr_en = 1'b1; wr_addr = 8'h11; wr_data = 8'h00; end
                3: begin wr_en = 1'b1; wr_addr = 8'h40; wr_data = 8'h08; end
                4: begin wr_en = 1'b1; wr_addr = 8'h41; wr_data = 8'h00; end
                default: wr_en = 1'b0;
            endcase
            @(negedge clk);
        end
        h_old = 0;
        for (int i = 0; i < 20; i++) h_old += int'(smp[i]);
        h_new = 0;
        for (int i = 20; i < 32; i++) h_new += int'(smp[i]);
        chk(h_old == 5, "R8 current period keeps old duty", h_old, 5);
        chk(!smp[19] && smp[20], "R8 old period length kept", smp[20], 1);
        chk(h_new == 8, "R8 new duty after wrap", h_new, 8);
        chk(!smp[31] && smp[32], "R8 new period length", smp[32], 1);
    endtask

    task automatic t_example;
        int hits;
        bit at_half, at_end;
        reg_wr(8'h00, 8'h00);
        set_chan(6, 50000, 25000);
        reg_wr(8'h00, 8'h40);
        @(negedge clk);
        hits = 0; at_half = 1'b1;
        for (int i = 0; i < 50000; i++) begin
            hits += int'(pwm_out[6]);
            if (i == 25000) at_half = pwm_out[6];
            @(negedge clk);
        end
        at_end = pwm_out[6];
        chk(hits == 25000, "R3 half of 50000 cycles high", hits, 25000);
        chk(at_half == 1'b0, "R3 low after 25000 cycles", at_half, 0);
        chk(at_end == 1'b1, "R3 rises again at cycle 50000", at_end, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regs;
        t_basic;
        t_multi;
        t_global;
        t_extremes;
        t_wrap;
        t_example;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule